// File: doc/BRIEF.md
# Floating-Point Dual-Issue Pairing Checker

This block sits behind the instruction decoder of a two-pipe in-order core. Each cycle it looks at two adjacent decoded slots and at the class of the instruction that follows them. It decides whether the second slot can issue in the secondary pipe alongside the first. Floating-point work has a single legal pairing form. An arithmetic, load, compare, sign or absolute-value operation goes in the primary slot. A register-exchange goes in the secondary slot, and it only renames stack entries, so it never stalls. The pair costs one clock when the instruction after the exchange is also floating point. It costs two clocks when that instruction is integer, is some other non-floating-point class, or is absent.

Every input is a 4-bit class code with a valid bit. The verdict is registered, so it appears one clock after the slots are presented. It has three parts: a pair-enable flag, an imperfect-pair penalty flag and the number of issue cycles the group occupies.

Top module: `fp_pair_check`

## Requirements
- R1: While reset is asserted and on the first clock after release, `grp_vld`, `pair_en`, `pair_penalty` and `issue_cycles` are all 0.
- R2: Each verdict appears on the outputs exactly one clock after the slots are sampled. `grp_vld` equals the `slot0_vld` sampled on the previous clock.
- R3: Class codes: 0 = integer or other non-FP, 1 load, 2 add, 3 subtract, 4 multiply, 5 divide, 6 compare, 7 sign change, 8 absolute value, 9 exchange, 10 store, 11 compare-and-pop-twice, 12 other FP. Codes 13 to 15 are reserved and count as non-FP. Only codes 1 to 12 count as floating point.
- R4: `pair_en` is 1 when both slots are valid, slot 1 holds class 9 and slot 0 holds one of classes 1 to 8 or 11.
- R5: When slot 1 holds any class other than exchange (9), `pair_en` is 0 and `issue_cycles` is 1.
- R6: When slot 0 holds a class outside {1..8, 11}, `pair_en` is 0, even with an exchange in slot 1. Examples are store, exchange, other FP and non-FP.
- R7: When either slot is invalid, `pair_en` is 0. An invalid slot 0 gives `grp_vld`=0 and `issue_cycles`=0.
- R8: A pair whose following slot is valid and floating point has `pair_penalty`=0 and `issue_cycles`=1.
- R9: A pair whose following slot is non-FP (code 0 or 13 to 15) or is invalid has `pair_penalty`=1 and `issue_cycles`=2.
- R10: An unpaired valid slot 0 issues alone with `pair_penalty`=0 and `issue_cycles`=1, whatever the following slot holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot0_cls | input | 4 | Class of the primary-slot instruction |
| slot0_vld | input | 1 | Primary slot holds an instruction |
| slot1_cls | input | 4 | Class of the secondary-slot instruction |
| slot1_vld | input | 1 | Secondary slot holds an instruction |
| next_cls | input | 4 | Class of the instruction after the group |
| next_vld | input | 1 | Following slot holds an instruction |
| grp_vld | output | 1 | Registered verdict refers to a valid group |
| pair_en | output | 1 | Secondary slot issues with the primary slot |
| pair_penalty | output | 1 | Pair is imperfect and costs an extra clock |
| issue_cycles | output | 2 | Clocks taken by the group (0, 1 or 2) |

## Verification
Two of the block's functions land in one verdict: the pair decision and the imperfect-pair penalty. They coincide whenever an eligible primary op is followed by an exchange and then by a non-floating-point or missing instruction. The bench provokes this case with several primary classes and with both an integer code and a reserved code in the following slot. It also sends the same pair followed by floating-point instructions to show that the penalty disappears. Each verdict is judged by checking all three outputs together against the class-code rules, so a penalty without a pair, or a two-clock count without a penalty, is reported.

// File: rtl/fp_pair_pkg.sv
package fp_pair_pkg;
    localparam int CLS_W = 4;
    localparam int CYC_W = 2;

    localparam logic [CLS_W-1:0] CLS_NONFP   = 4'd0;
    localparam logic [CLS_W-1:0] CLS_LOAD    = 4'd1;
    localparam logic [CLS_W-1:0] CLS_ADD     = 4'd2;
    localparam logic [CLS_W-1:0] CLS_SUB     = 4'd3;
    localparam logic [CLS_W-1:0] CLS_MUL     = 4'd4;
    localparam logic [CLS_W-1:0] CLS_DIV     = 4'd5;
    localparam logic [CLS_W-1:0] CLS_CMP     = 4'd6;
    localparam logic [CLS_W-1:0] CLS_NEG     = 4'd7;
    localparam logic [CLS_W-1:0] CLS_ABS     = 4'd8;
    localparam logic [CLS_W-1:0] CLS_XCHG    = 4'd9;
    localparam logic [CLS_W-1:0] CLS_STORE   = 4'd10;
    localparam logic [CLS_W-1:0] CLS_CMPPOP2 = 4'd11;
    localparam logic [CLS_W-1:0] CLS_FPOTHER = 4'd12;

    typedef struct packed {
        logic             grp_vld;
        logic             pair_en;
        logic             penalty;
        logic [CYC_W-1:0] cycles;
    } pair_verdict_t;

    typedef struct packed {
        logic is_fp;
        logic u_ok;
        logic is_xchg;
    } cls_attr_t;
endpackage

// File: rtl/fp_cls_decode.sv
module fp_cls_decode
    import fp_pair_pkg::*;
#(
    parameter int W = CLS_W
) (
    input  logic [W-1:0] cls,
    input  logic         vld,
    output cls_attr_t    attr
);
    always_comb begin
        attr = '0;
        if (vld) begin
            attr.is_fp   = (cls >= CLS_LOAD) && (cls <= CLS_FPOTHER);
            attr.is_xchg = (cls == CLS_XCHG);
            unique case (cls)
                CLS_LOAD, CLS_ADD, CLS_SUB, CLS_MUL, CLS_DIV,
                CLS_CMP, CLS_NEG, CLS_ABS, CLS_CMPPOP2: attr.u_ok = 1'b1;
                default:                                attr.u_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fp_pair_rule.sv
module fp_pair_rule
    import fp_pair_pkg::*;
(
    input  logic          s0_vld,
    input  cls_attr_t     s0,
    input  cls_attr_t     s1,
    input  cls_attr_t     nx,
    output pair_verdict_t verdict
);
    logic can_pair;
    logic slow;

    always_comb begin
        can_pair = s0.u_ok && s1.is_xchg;
        slow     = can_pair && !nx.is_fp;
        verdict  = '0;
        if (s0_vld) begin
            verdict.grp_vld = 1'b1;
            verdict.pair_en = can_pair;
            verdict.penalty = slow;
            verdict.cycles  = slow ? CYC_W'(2) : CYC_W'(1);
        end
    end
endmodule

// File: rtl/fp_pair_check.sv
module fp_pair_check
    import fp_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLS_W-1:0] slot0_cls,
    input  logic             slot0_vld,
    input  logic [CLS_W-1:0] slot1_cls,
    input  logic             slot1_vld,
    input  logic [CLS_W-1:0] next_cls,
    input  logic             next_vld,
    output logic             grp_vld,
    output logic             pair_en,
    output logic             pair_penalty,
    output logic [CYC_W-1:0] issue_cycles
);
    localparam int NSLOT = 3;

    logic [NSLOT-1:0][CLS_W-1:0] cls_in;
    logic [NSLOT-1:0]            vld_in;
    cls_attr_t [NSLOT-1:0]       attr;
    pair_verdict_t               verdict_d, verdict_q;

    assign cls_in = {next_cls, slot1_cls, slot0_cls};
    assign vld_in = {next_vld, slot1_vld, slot0_vld};

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        fp_cls_decode #(.W(CLS_W)) u_dec (
            .cls  (cls_in[g]),
            .vld  (vld_in[g]),
            .attr (attr[g])
        );
    end

    fp_pair_rule u_rule (
        .s0_vld  (slot0_vld),
        .s0      (attr[0]),
        .s1      (attr[1]),
        .nx      (attr[2]),
        .verdict (verdict_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign grp_vld      = verdict_q.grp_vld;
    assign pair_en      = verdict_q.pair_en;
    assign pair_penalty = verdict_q.penalty;
    assign issue_cycles = verdict_q.cycles;
endmodule

// File: rtl/fp_pair_check_sva.sv
module fp_pair_check_sva
    import fp_pair_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CLS_W-1:0] slot0_cls,
    input logic             slot0_vld,
    input logic [CLS_W-1:0] slot1_cls,
    input logic             slot1_vld,
    input logic             grp_vld,
    input logic             pair_en,
    input logic             pair_penalty,
    input logic [CYC_W-1:0] issue_cycles
);
    assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot0_vld |=> grp_vld);
    assert_no_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_vld |=> (!grp_vld && !pair_en && issue_cycles == '0));
    assert_half_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slot1_vld |=> !pair_en);
    assert_xchg_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_cls != CLS_XCHG) |=> !pair_en);
    assert_store_no_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot0_cls == CLS_STORE || slot0_cls == CLS_XCHG) |=> !pair_en);
    assert_penalty_needs_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_penalty |-> (pair_en && issue_cycles == 2'd2));
    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_vld && !pair_penalty) |-> (issue_cycles == 2'd1));
endmodule

bind fp_pair_check fp_pair_check_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot0_cls    (slot0_cls),
    .slot0_vld    (slot0_vld),
    .slot1_cls    (slot1_cls),
    .slot1_vld    (slot1_vld),
    .grp_vld      (grp_vld),
    .pair_en      (pair_en),
    .pair_penalty (pair_penalty),
    .issue_cycles (issue_cycles)
);

// File: tb/fp_pair_check_tb.sv
module fp_pair_check_tb;
    import fp_pair_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CLS_W-1:0] slot0_cls = '0, slot1_cls = '0, next_cls = '0;
    logic             slot0_vld = 1'b0, slot1_vld = 1'b0, next_vld = 1'b0;
    logic             grp_vld, pair_en, pair_penalty;
    logic [CYC_W-1:0] issue_cycles;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        time         t;
        logic [4:0]  exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    fp_pair_check u_dut (
        .clk(clk), .rst_n(rst_n),
        .slot0_cls(slot0_cls), .slot0_vld(slot0_vld),
        .slot1_cls(slot1_cls), .slot1_vld(slot1_vld),
        .next_cls(next_cls), .next_vld(next_vld),
        .grp_vld(grp_vld), .pair_en(pair_en),
        .pair_penalty(pair_penalty), .issue_cycles(issue_cycles)
    );

    function automatic logic [4:0] model(logic [3:0] c0, logic v0, logic [3:0] c1,
                                         logic v1, logic [3:0] cn, logic vn);
        logic u_ok, pr, fpn, pen;
        u_ok = (c0 >= 4'd1 && c0 <= 4'd8) || c0 == 4'd11;
        pr   = v0 && v1 && u_ok && c1 == 4'd9;
        fpn  = vn && cn >= 4'd1 && cn <= 4'd12;
        pen  = pr && !fpn;
        if (!v0) return 5'b0;
        return {1'b1, pr, pen, pen ? 2'd2 : 2'd1};
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {vld,pair,pen,cyc}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(string req, logic [3:0] c0, logic v0, logic [3:0] c1,
                         logic v1, logic [3:0] cn, logic vn);
        item_t it;
        @(negedge clk);
        slot0_cls = c0; slot0_vld = v0;
        slot1_cls = c1; slot1_vld = v1;
        next_cls  = cn; next_vld  = vn;
        it.t = $time; it.exp = model(c0, v0, c1, v1, cn, vn); it.req = req;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #0.1;
            while (sb.size() > 0 && sb[0].t < $time) begin
                item_t it;
                it = sb.pop_front();
                check(it.req, {grp_vld, pair_en, pair_penalty, issue_cycles}, it.exp);
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R1 in reset", {grp_vld, pair_en, pair_penalty, issue_cycles}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {grp_vld, pair_en, pair_penalty, issue_cycles}, 5'b0);
        // R4 / R8: eligible primaries, exchange, FP next -> perfect pair
        drive("R4 R8 load+xchg+add", 4'd1, 1, 4'd9, 1, 4'd2, 1);
        drive("R4 R8 mul+xchg+store", 4'd4, 1, 4'd9, 1, 4'd10, 1);
        drive("R4 R8 cmppop2+xchg+fpother", 4'd11, 1, 4'd9, 1, 4'd12, 1);
        drive("R4 R8 abs+xchg+xchg", 4'd8, 1, 4'd9, 1, 4'd9, 1);
        // R9: pair and penalty in the same verdict
        drive("R9 div+xchg+int", 4'd5, 1, 4'd9, 1, 4'd0, 1);
        drive("R9 add+xchg+reserved", 4'd2, 1, 4'd9, 1, 4'd14, 1);
        drive("R9 neg+xchg+none", 4'd7, 1, 4'd9, 1, 4'd1, 0);
        drive("R9 cmp+xchg+reserved15", 4'd6, 1, 4'd9, 1, 4'd15, 1);
        // R5: secondary not exchange
        drive("R5 add+add", 4'd2, 1, 4'd2, 1, 4'd0, 1);
        drive("R5 load+int", 4'd1, 1, 4'd0, 1, 4'd1, 1);
        // R6: ineligible primary
        drive("R6 store+xchg", 4'd10, 1, 4'd9, 1, 4'd0, 1);
        drive("R6 xchg+xchg", 4'd9, 1, 4'd9, 1, 4'd2, 1);
        drive("R6 fpother+xchg", 4'd12, 1, 4'd9, 1, 4'd0, 1);
        drive("R6 int+xchg", 4'd0, 1, 4'd9, 1, 4'd0, 1);
        drive("R3 reserved13+xchg", 4'd13, 1, 4'd9, 1, 4'd0, 1);
        // R7: invalid slots
        drive("R7 slot1 invalid", 4'd3, 1, 4'd9, 0, 4'd0, 1);
        drive("R7 slot0 invalid", 4'd3, 0, 4'd9, 1, 4'd0, 1);
        // R10: unpaired with non-FP next
        drive("R10 sub alone int next", 4'd3, 1, 4'd10, 1, 4'd0, 0);
        // R2: back-to-back alternation
        for (int i = 0; i < 6; i++)
            drive("R2 alternating", 4'd2, (i % 2) == 0, 4'd9, 1, 4'd0, (i % 3) == 0);
        drive("R7 idle", 4'd0, 0, 4'd0, 0, 4'd0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule